// File: doc/BRIEF.md
# Dual-Handshake Circular Queue Controller

This block keeps the write (put) and read (get) pointers of a circular message queue. The queue is shared by a local processor and a remote processor. The message storage lives elsewhere. This block only tracks positions and reports whether the queue is full or empty.

The queue depth is set at run time through a last-entry index held in the local control word. Each put or get strobe moves its pointer forward by one. A pointer wraps back to zero after the last index.

The pointers can be returned to zero only by a two-party agreement. The local side sets a sticky reset bit, and the remote side raises a request bit. Whichever bit comes first stays set and waits for the other. Once both are set, the pointers and both handshake bits clear together.

Top module: `msgq_dual_reset_ctrl`

## Requirements
- R1: After a synchronous reset, `put_ptr` and `get_ptr` are 0 and `ctrl_rdata` is 0. Because the last-entry index is 0, both `full` and `empty` read 1.
- R2: `ctrl_rdata[15:0]` holds the last-entry index, and the queue has that index plus one slots.
  - A write cycle (`ctrl_wr`) loads the field from `ctrl_wdata[15:0]`.
  - A set cycle (`ctrl_set`) ORs `ctrl_wdata[15:0]` into the field.
- R3: `ctrl_rdata[29:16]` always reads 0, whatever value is written or set.
- R4: `ctrl_rdata[31]` is the local reset bit.
  - A write or set cycle with `ctrl_wdata[31]`=1 sets it.
  - A 0 in that position never clears it.
- R5: `ctrl_rdata[30]` is the remote request bit. It is set only by a `remote_req` cycle; a 1 in `ctrl_wdata[30]` has no effect.
- R6: While only one of bits 31 and 30 is set, the pointers are not cleared and that bit stays set. This holds in either order of arrival.
- R7: In the cycle after bits 31 and 30 are both seen set, `put_ptr`, `get_ptr`, bit 31 and bit 30 all become 0 together. The last-entry index is kept.
- R8: A pointer that advances from a value equal to or above the last-entry index becomes 0. Otherwise it becomes its value plus one.
- R9: `empty` is 1 when `put_ptr` equals `get_ptr`. `full` is 1 when the wrapped successor of `put_ptr` equals `get_ptr`. A `put_stb` while full is ignored, and a `get_stb` while empty is ignored.
- R10: A put or get strobe in the cycle in which the handshake clear takes effect is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Local write of the control word |
| ctrl_set | input | 1 | Local bitwise set of the control word |
| ctrl_wdata | input | 32 | Data for a write or set cycle |
| ctrl_rdata | output | 32 | Control word: bit 31 local reset, bit 30 remote request, 15:0 last-entry index |
| remote_req | input | 1 | Remote processor request to reinitialize the pointers |
| put_stb | input | 1 | Advance the put pointer |
| get_stb | input | 1 | Advance the get pointer |
| put_ptr | output | 16 | Current put pointer |
| get_ptr | output | 16 | Current get pointer |
| full | output | 1 | Queue full flag (registered) |
| empty | output | 1 | Queue empty flag (registered) |

## Verification
The hardest state to reach is the one where a strobe arrives in exactly the cycle the joint clear takes effect. This needs both handshake bits to be visible in the same cycle, with nonzero pointers and a live strobe.

The bench sets the local bit first and waits several idle cycles to show it holds. It then pulses the remote request together with a put, and keeps the put strobe high into the following cycle, where the clear must win.

The reverse order of arrival is driven separately, using a set cycle for the local bit. The pointer table crosses both full and empty, with simultaneous put and get strobes at each boundary.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  // Control word layout; the bit positions are decoded by software on both sides
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned INDEX_W  = 16;
  localparam int unsigned LOC_POS  = 31;
  localparam int unsigned REM_POS  = 30;
  localparam int unsigned NUM_PTRS = 2;
  localparam int unsigned PUT_SEL  = 0;
  localparam int unsigned GET_SEL  = 1;
endpackage

// File: rtl/msgq_size_reg.sv
module msgq_size_reg #(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             set_en,
  input  logic [IDX_W-1:0] wdata,
  output logic [IDX_W-1:0] last_q,
  output logic [IDX_W-1:0] last_nxt
);
  // write replaces the index, set ORs new ones into it
  always_comb begin
    last_nxt = last_q;
    if (wr_en)       last_nxt = wdata;
    else if (set_en) last_nxt = last_q | wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= last_nxt;
  end
endmodule

// File: rtl/msgq_handshake.sv
module msgq_handshake (
  input  logic clk,
  input  logic rst,
  input  logic loc_set,
  input  logic rem_set,
  output logic loc_q,
  output logic rem_q,
  output logic fire
);
  logic loc_nxt;
  logic rem_nxt;

  // both parties agreed in a previous cycle: clear now
  assign fire = loc_q & rem_q;

  always_comb begin
    if (fire) begin
      loc_nxt = 1'b0;
      rem_nxt = 1'b0;
    end else begin
      loc_nxt = loc_q | loc_set;
      rem_nxt = rem_q | rem_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_q <= 1'b0;
      rem_q <= 1'b0;
    end else begin
      loc_q <= loc_nxt;
      rem_q <= rem_nxt;
    end
  end
endmodule

// File: rtl/msgq_ptr.sv
module msgq_ptr #(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] ptr_q,
  output logic [IDX_W-1:0] ptr_nxt
);
  logic [IDX_W-1:0] succ;

  // wrap at or beyond the last index so a shrunk queue still recovers
  assign succ = (ptr_q >= last) ? '0 : ptr_q + 1'b1;

  always_comb begin
    ptr_nxt = ptr_q;
    if (clr)      ptr_nxt = '0;
    else if (adv) ptr_nxt = succ;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/msgq_dual_reset_ctrl.sv
module msgq_dual_reset_ctrl
  import msgq_pkg::*;
#(
  parameter int unsigned IDX_W  = INDEX_W,
  parameter int unsigned CTRL_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              ctrl_set,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              remote_req,
  input  logic              put_stb,
  input  logic              get_stb,
  output logic [IDX_W-1:0]  put_ptr,
  output logic [IDX_W-1:0]  get_ptr,
  output logic              full,
  output logic              empty
);
  localparam int unsigned RSV_W = CTRL_W - 2 - IDX_W;

  logic [IDX_W-1:0] last_q, last_nxt;
  logic             loc_q, rem_q, fire;
  logic             loc_set;
  logic [IDX_W-1:0] ptr_q   [NUM_PTRS];
  logic [IDX_W-1:0] ptr_nxt [NUM_PTRS];
  logic             adv     [NUM_PTRS];
  logic             full_q, empty_q;
  logic [IDX_W-1:0] put_succ_nxt;

  msgq_size_reg #(.IDX_W(IDX_W)) u_size (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ctrl_wr),
    .set_en   (ctrl_set),
    .wdata    (ctrl_wdata[IDX_W-1:0]),
    .last_q   (last_q),
    .last_nxt (last_nxt)
  );

  // a zero in the local bit position never clears it
  assign loc_set = (ctrl_wr | ctrl_set) & ctrl_wdata[LOC_POS];

  msgq_handshake u_hs (
    .clk     (clk),
    .rst     (rst),
    .loc_set (loc_set),
    .rem_set (remote_req),
    .loc_q   (loc_q),
    .rem_q   (rem_q),
    .fire    (fire)
  );

  // a clear in progress swallows any strobe of the same cycle
  assign adv[PUT_SEL] = put_stb & ~full_q  & ~fire;
  assign adv[GET_SEL] = get_stb & ~empty_q & ~fire;

  for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
    msgq_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk     (clk),
      .rst     (rst),
      .clr     (fire),
      .adv     (adv[g]),
      .last    (last_q),
      .ptr_q   (ptr_q[g]),
      .ptr_nxt (ptr_nxt[g])
    );
  end

  // flags derived from next-state values so they line up with the pointers
  assign put_succ_nxt = (ptr_nxt[PUT_SEL] >= last_nxt) ? '0
                      : ptr_nxt[PUT_SEL] + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b1;
      empty_q <= 1'b1;
    end else begin
      full_q  <= (put_succ_nxt == ptr_nxt[GET_SEL]);
      empty_q <= (ptr_nxt[PUT_SEL] == ptr_nxt[GET_SEL]);
    end
  end

  assign ctrl_rdata = {loc_q, rem_q, {RSV_W{1'b0}}, last_q};
  assign put_ptr    = ptr_q[PUT_SEL];
  assign get_ptr    = ptr_q[GET_SEL];
  assign full       = full_q;
  assign empty      = empty_q;
endmodule

// File: rtl/msgq_checker.sv
module msgq_checker #(
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned CTRL_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              remote_req,
  input logic              put_stb,
  input logic              get_stb,
  input logic [CTRL_W-1:0] ctrl_rdata,
  input logic [IDX_W-1:0]  put_ptr,
  input logic [IDX_W-1:0]  get_ptr,
  input logic              full,
  input logic              empty
);
  logic both;
  assign both = ctrl_rdata[CTRL_W-1] & ctrl_rdata[CTRL_W-2];

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[CTRL_W-3:IDX_W] == '0);

  // R4
  local_bit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[CTRL_W-1] && !ctrl_rdata[CTRL_W-2] |=> ctrl_rdata[CTRL_W-1]);

  // R5
  remote_source_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_rdata[CTRL_W-2] && !remote_req |=> !ctrl_rdata[CTRL_W-2]);

  // R6
  no_early_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !both && !put_stb |=> $stable(put_ptr));

  // R7
  joint_clear_chk: assert property (@(posedge clk) disable iff (rst)
    both |=> (put_ptr == '0) && (get_ptr == '0) && !ctrl_rdata[CTRL_W-1] && !ctrl_rdata[CTRL_W-2]);

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    put_stb && !full && !both && (put_ptr >= ctrl_rdata[IDX_W-1:0]) |=> put_ptr == '0);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    full && !both |=> $stable(put_ptr));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    empty && !both |=> $stable(get_ptr));

  // R9
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    empty == (put_ptr == get_ptr));
endmodule

bind msgq_dual_reset_ctrl msgq_checker #(.IDX_W(IDX_W), .CTRL_W(CTRL_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .remote_req (remote_req),
  .put_stb    (put_stb),
  .get_stb    (get_stb),
  .ctrl_rdata (ctrl_rdata),
  .put_ptr    (put_ptr),
  .get_ptr    (get_ptr),
  .full       (full),
  .empty      (empty)
);

// File: tb/test_msgq_dual_reset_ctrl.sv
`timescale 1ns/1ps
module test_msgq_dual_reset_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        ctrl_wr, ctrl_set, remote_req, put_stb, get_stb;
  logic [31:0] ctrl_wdata, ctrl_rdata;
  logic [15:0] put_ptr, get_ptr;
  logic        full, empty;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  msgq_dual_reset_ctrl i_msgq_dual_reset_ctrl (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_set(ctrl_set),
    .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata), .remote_req(remote_req),
    .put_stb(put_stb), .get_stb(get_stb), .put_ptr(put_ptr), .get_ptr(get_ptr),
    .full(full), .empty(empty)
  );

  // op: 0 idle, 1 put, 2 get, 3 put+get, 4 write index; then data, exp put, exp get, full, empty
  localparam int NV = 13;
  localparam logic [52:0] VEC [NV] = '{
    {3'd4, 16'd3, 16'd0, 16'd0, 1'b0, 1'b1},
    {3'd2, 16'd0, 16'd0, 16'd0, 1'b0, 1'b1},
    {3'd1, 16'd0, 16'd1, 16'd0, 1'b0, 1'b0},
    {3'd1, 16'd0, 16'd2, 16'd0, 1'b0, 1'b0},
    {3'd1, 16'd0, 16'd3, 16'd0, 1'b1, 1'b0},
    {3'd1, 16'd0, 16'd3, 16'd0, 1'b1, 1'b0},
    {3'd3, 16'd0, 16'd3, 16'd1, 1'b0, 1'b0},
    {3'd1, 16'd0, 16'd0, 16'd1, 1'b1, 1'b0},
    {3'd2, 16'd0, 16'd0, 16'd2, 1'b0, 1'b0},
    {3'd3, 16'd0, 16'd1, 16'd3, 1'b0, 1'b0},
    {3'd2, 16'd0, 16'd1, 16'd0, 1'b0, 1'b0},
    {3'd2, 16'd0, 16'd1, 16'd1, 1'b0, 1'b1},
    {3'd3, 16'd0, 16'd2, 16'd1, 1'b0, 1'b0}
  };

  task automatic idle_inputs();
    ctrl_wr = 0; ctrl_set = 0; ctrl_wdata = '0; remote_req = 0; put_stb = 0; get_stb = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_q(input string req, input logic [15:0] p, input logic [15:0] g,
                       input logic f, input logic e);
    chk({req, " put_ptr"}, {16'd0, put_ptr}, {16'd0, p});
    chk({req, " get_ptr"}, {16'd0, get_ptr}, {16'd0, g});
    chk({req, " full"}, {31'd0, full}, {31'd0, f});
    chk({req, " empty"}, {31'd0, empty}, {31'd0, e});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 ctrl", ctrl_rdata, 32'h0);
    chk_q("R1", 16'd0, 16'd0, 1'b1, 1'b1);

    // R3 and R5: reserved and request bits ignore writes
    ctrl_wr = 1; ctrl_wdata = 32'h7FFF_0005; tick(); idle_inputs();
    chk("R3 R5 write", ctrl_rdata, 32'h0000_0005);
    // R2 set cycle ORs into the index
    ctrl_set = 1; ctrl_wdata = 32'h0000_0002; tick(); idle_inputs();
    chk("R2 set", ctrl_rdata, 32'h0000_0007);
    // R9 one-slot queue after size 0: both flags, strobes ignored
    ctrl_wr = 1; ctrl_wdata = 32'h0; tick(); idle_inputs();
    put_stb = 1; get_stb = 1; tick(); idle_inputs();
    chk_q("R9 single slot", 16'd0, 16'd0, 1'b1, 1'b1);

    // R8 R9 table walk with last index 3
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][52:50])
        3'd1: put_stb = 1;
        3'd2: get_stb = 1;
        3'd3: begin put_stb = 1; get_stb = 1; end
        3'd4: begin ctrl_wr = 1; ctrl_wdata = {16'd0, VEC[i][49:34]}; end
        default: ;
      endcase
      tick(); idle_inputs();
      chk_q($sformatf("R8 R9 vec%0d", i), VEC[i][33:18], VEC[i][17:2], VEC[i][1], VEC[i][0]);
    end
    chk("R2 write", ctrl_rdata, 32'h0000_0003);

    // R6 local first: bit waits, pointers kept
    ctrl_wr = 1; ctrl_wdata = 32'h8000_0003; tick(); idle_inputs();
    repeat (3) tick();
    chk("R6 local waits", ctrl_rdata, 32'h8000_0003);
    chk_q("R6 local waits", 16'd2, 16'd1, 1'b0, 1'b0);
    // R4 a zero does not clear the local bit
    ctrl_wr = 1; ctrl_wdata = 32'h0000_0003; tick(); idle_inputs();
    chk("R4 zero write", ctrl_rdata, 32'h8000_0003);
    // remote request together with a put; both bits now visible
    remote_req = 1; put_stb = 1; tick(); idle_inputs();
    chk("R7 both visible", ctrl_rdata, 32'hC000_0003);
    chk_q("R7 before clear", 16'd3, 16'd1, 1'b0, 1'b0);
    // R10 put in the clear cycle is discarded
    put_stb = 1; tick(); idle_inputs();
    chk("R7 bits cleared", ctrl_rdata, 32'h0000_0003);
    chk_q("R10 clear wins", 16'd0, 16'd0, 1'b0, 1'b1);

    // R6 remote first
    put_stb = 1; tick(); tick(); idle_inputs();
    remote_req = 1; tick(); idle_inputs();
    repeat (3) tick();
    chk("R6 remote waits", ctrl_rdata, 32'h4000_0003);
    chk_q("R6 remote waits", 16'd2, 16'd0, 1'b0, 1'b0);
    ctrl_set = 1; ctrl_wdata = 32'h8000_0000; tick(); idle_inputs();
    chk("R4 set local", ctrl_rdata, 32'hC000_0003);
    get_stb = 1; tick(); idle_inputs();
    chk("R7 remote-first clear", ctrl_rdata, 32'h0000_0003);
    chk_q("R10 get discarded", 16'd0, 16'd0, 1'b0, 1'b1);

    // R1 reset in mid operation
    put_stb = 1; tick(); idle_inputs();
    rst = 1; tick(); rst = 0; tick();
    chk("R1 re-reset", ctrl_rdata, 32'h0);
    chk_q("R1 re-reset", 16'd0, 16'd0, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule